// File: doc/BRIEF.md
# Random Byte Harvester

The block turns a one-bit noise source into a stream of random bytes for a host. A local pacer samples the noise input once every fixed number of clock cycles and shifts each sample into an accumulator. After eight samples the byte is complete and waits there. The block hands it over only when the host's byte-pending input is low, which means the previous byte has been consumed.

A handover places the byte on the parallel output first. One cycle later the ready strobe toggles. If interrupts are enabled at that point, the block also asserts an open-drain pull-low request on the interrupt line for a fixed number of cycles and then releases it. An external pull-up supplies the rising edge that the interrupt controller detects. Until that pulse has finished, no further handover starts.

Top module: `rbyte_harvester`

## Requirements
- R1: The noise input passes through SYNC_STAGES flops and is sampled once every SAMPLE_DIV cycles after reset. With pending low and the line idle, the first strobe toggle comes 8*SAMPLE_DIV+2 clock edges after reset is released.
- R2: A byte is built from eight consecutive kept samples. The earliest sample lands in bit 0 and the latest in bit 7.
- R3: While a complete byte waits for handover, further samples are discarded. The byte handed over later holds exactly the eight samples kept before the wait.
- R4: A handover takes place only if pending_i was low at the edge before the strobe edge.
- R5: While pending_i stays high, byte_o and strobe_o keep their values.
- R6: byte_o takes the new byte one clock edge before strobe_o toggles, and it does not change at the toggle edge.
- R7: strobe_o toggles exactly once per handed-over byte. It never toggles when no complete byte exists.
- R8: If irq_en_i is high at the strobe edge, irq_pull_o rises at that same edge. It stays high for exactly IRQ_LOW_CYCLES cycles and then falls.
- R9: If irq_en_i is low at the strobe edge, irq_pull_o stays low. irq_pull_o never rises at any edge other than a strobe edge.
- R10: No handover starts while irq_pull_o is high. A pulse is never shortened or restarted.
- R11: Asynchronous active-low reset clears the accumulator and its bit count, sets byte_o to 0 and strobe_o to 0, and releases irq_pull_o (0), even in the middle of a pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| noise_i | input | 1 | Asynchronous one-bit noise source |
| pending_i | input | 1 | High while the host has not yet read the last byte |
| irq_en_i | input | 1 | High to allow interrupt pulses |
| byte_o | output | BYTE_W | Last handed-over byte |
| strobe_o | output | 1 | Toggles once per new byte |
| irq_pull_o | output | 1 | 1 = pull the interrupt line low; 0 = release it |

## Verification
The bench builds the noise stream from an arithmetic byte sequence that covers all 256 values, so a design that reverses the bit order or starts a byte one sample late produces wrong bytes. Holding pending high over several byte periods exposes a design that overwrites the waiting byte or lets samples leak into it: the byte appears at the wrong time or comes out shifted. The interrupt width is set longer than one byte period, so a design that hands over a byte during a pulse produces a strobe edge while the line is still pulled low. Resetting in the middle of a pulse catches a design that keeps the line pulled low after reset.

// File: rtl/rbh_pkg.sv
package rbh_pkg;

   // Shortest interrupt pull-low accepted, in picoseconds.
   localparam int unsigned MIN_IRQ_LOW_PS = 100_000;

   // Two-step handover: load the byte, then announce it.
   typedef enum logic {
      XF_WAIT     = 1'b0,
      XF_ANNOUNCE = 1'b1
   } xfer_state_e;

endpackage

// File: rtl/rbh_noise_sync.sv
module rbh_noise_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic d_i,
   output logic q_o
);

   generate
      if (STAGES > 8) begin : g_bad_stages
         $error("rbh_noise_sync: STAGES must be 0..8");
      end

      if (STAGES == 0) begin : g_bypass
         // Source is already synchronous to clk_i.
         assign q_o = d_i;
      end else begin : g_chain
         logic [STAGES-1:0] ff_q;
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) ff_q <= '0;
            else         ff_q <= (ff_q << 1) | STAGES'(d_i);
         end
         assign q_o = ff_q[STAGES-1];
      end
   endgenerate

endmodule

// File: rtl/rbh_sample_pacer.sv
module rbh_sample_pacer #(
   parameter int unsigned DIV = 4
) (
   input  logic clk_i,
   input  logic rst_ni,
   output logic tick_o
);

   localparam int unsigned CW = (DIV > 1) ? $clog2(DIV) : 1;

   generate
      if (DIV == 0) begin : g_bad_div
         $error("rbh_sample_pacer: DIV must be at least 1");
      end

      if (DIV == 1) begin : g_every
         assign tick_o = 1'b1;
      end else begin : g_count
         localparam logic [CW-1:0] LAST = CW'(DIV - 1);
         logic [CW-1:0] cnt_q;

         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni)            cnt_q <= '0;
            else if (cnt_q == LAST) cnt_q <= '0;
            else                    cnt_q <= cnt_q + 1'b1;
         end

         assign tick_o = (cnt_q == LAST);

         // R1: ticks are separated by at least one idle cycle
         assert_tick_spacing_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
            tick_o |=> !tick_o)
            else $error("tick_o high on consecutive cycles");
      end
   endgenerate

endmodule

// File: rtl/rbh_shift_accum.sv
module rbh_shift_accum #(
   parameter int unsigned W         = 8,
   parameter bit          LSB_FIRST = 1'b1
) (
   input  logic         clk_i,
   input  logic         rst_ni,
   input  logic         tick_i,
   input  logic         bit_i,
   input  logic         take_i,
   output logic [W-1:0] word_o,
   output logic         full_o
);

   localparam int unsigned CNT_W = $clog2(W + 1);
   localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(W);

   logic [W-1:0]     sh_q;
   logic [W-1:0]     sh_next;
   logic [CNT_W-1:0] cnt_q;

   generate
      if (W < 2) begin : g_bad_w
         $error("rbh_shift_accum: W must be at least 2");
      end

      if (LSB_FIRST) begin : g_lsb
         // Oldest sample ends up in bit 0.
         assign sh_next = {bit_i, sh_q[W-1:1]};
      end else begin : g_msb
         assign sh_next = {sh_q[W-2:0], bit_i};
      end
   endgenerate

   assign full_o = (cnt_q == FULL_CNT);
   assign word_o = sh_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         sh_q  <= '0;
         cnt_q <= '0;
      end else if (take_i) begin
         cnt_q <= '0;
      end else if (tick_i && !full_o) begin
         sh_q  <= sh_next;
         cnt_q <= cnt_q + 1'b1;
      end
   end

   // R3: a waiting byte is frozen until it is taken
   assert_full_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (full_o && !take_i) |=> (full_o && $stable(word_o)))
      else $error("waiting byte changed before handover");

   // R1: bit count moves only on a sample tick or a take
   assert_count_on_tick_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!tick_i && !take_i) |=> $stable(cnt_q))
      else $error("bit count moved without a tick");

   assert_count_bound_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cnt_q <= FULL_CNT)
      else $error("bit count beyond byte width");

endmodule

// File: rtl/rbh_irq_pulse.sv
module rbh_irq_pulse #(
   parameter int unsigned LOW_CYCLES = 10
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic start_i,
   output logic pull_o,
   output logic busy_o
);

   localparam int unsigned CW = $clog2(LOW_CYCLES + 1);
   localparam logic [CW-1:0] LOAD = CW'(LOW_CYCLES);

   logic [CW-1:0] left_q;
   logic [CW-1:0] width_q;

   generate
      if (LOW_CYCLES == 0) begin : g_bad_low
         $error("rbh_irq_pulse: LOW_CYCLES must be at least 1");
      end
   endgenerate

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)           left_q <= '0;
      else if (start_i)      left_q <= LOAD;
      else if (left_q != '0) left_q <= left_q - 1'b1;
   end

   assign pull_o = (left_q != '0);
   assign busy_o = pull_o;

   // Witness counter: how many cycles the line has been pulled so far.
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     width_q <= '0;
      else if (pull_o) width_q <= width_q + 1'b1;
      else             width_q <= '0;
   end

   // R10: a new pulse is never requested during a running one
   assert_no_restart_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      start_i |-> !busy_o)
      else $error("pulse restarted while active");

   assert_pulse_starts_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      start_i |=> pull_o)
      else $error("start did not pull the line");

   // R8: release happens only after the full width
   assert_pulse_width_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!pull_o && $past(pull_o)) |-> (width_q == LOAD))
      else $error("pulse width wrong");

endmodule

// File: rtl/rbyte_harvester.sv
module rbyte_harvester
   import rbh_pkg::*;
#(
   parameter int unsigned BYTE_W         = 8,
   parameter int unsigned SAMPLE_DIV     = 4,
   parameter int unsigned SYNC_STAGES    = 2,
   parameter int unsigned IRQ_LOW_CYCLES = 10,
   parameter int unsigned CLK_PERIOD_PS  = 10_000,
   parameter bit          LSB_FIRST      = 1'b1
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              noise_i,
   input  logic              pending_i,
   input  logic              irq_en_i,
   output logic [BYTE_W-1:0] byte_o,
   output logic              strobe_o,
   output logic              irq_pull_o
);

   localparam longint unsigned IRQ_LOW_PS = longint'(IRQ_LOW_CYCLES) * longint'(CLK_PERIOD_PS);

   generate
      if (IRQ_LOW_PS < MIN_IRQ_LOW_PS) begin : g_bad_irq_width
         $error("rbyte_harvester: IRQ_LOW_CYCLES too short for CLK_PERIOD_PS");
      end
   endgenerate

   logic              noise_s;
   logic              tick;
   logic              acc_full;
   logic [BYTE_W-1:0] acc_word;
   logic              take;
   logic              irq_start;
   logic              irq_busy;
   logic [BYTE_W-1:0] byte_q;
   logic              strobe_q;
   xfer_state_e       xf_q;

   rbh_noise_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .d_i   (noise_i),
      .q_o   (noise_s)
   );

   rbh_sample_pacer #(.DIV(SAMPLE_DIV)) u_pacer (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .tick_o(tick)
   );

   rbh_shift_accum #(.W(BYTE_W), .LSB_FIRST(LSB_FIRST)) u_accum (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .tick_i(tick),
      .bit_i (noise_s),
      .take_i(take),
      .word_o(acc_word),
      .full_o(acc_full)
   );

   rbh_irq_pulse #(.LOW_CYCLES(IRQ_LOW_CYCLES)) u_irq (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .start_i(irq_start),
      .pull_o (irq_pull_o),
      .busy_o (irq_busy)
   );

   // Handover: complete byte, host has read the last one, no announce or pulse in flight.
   assign take      = acc_full && !pending_i && (xf_q == XF_WAIT) && !irq_busy;
   assign irq_start = (xf_q == XF_ANNOUNCE) && irq_en_i;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         byte_q   <= '0;
         strobe_q <= 1'b0;
         xf_q     <= XF_WAIT;
      end else begin
         case (xf_q)
            XF_WAIT: begin
               if (take) begin
                  byte_q <= acc_word;
                  xf_q   <= XF_ANNOUNCE;
               end
            end
            XF_ANNOUNCE: begin
               strobe_q <= ~strobe_q;
               xf_q     <= XF_WAIT;
            end
            default: xf_q <= XF_WAIT;
         endcase
      end
   end

   assign byte_o   = byte_q;
   assign strobe_o = strobe_q;

   // R4: a strobe edge needs pending low at the handover edge
   assert_take_needs_free_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (strobe_o != $past(strobe_o)) |-> !$past(pending_i, 2))
      else $error("byte handed over while pending");

   // R6: data settles before the strobe
   assert_data_before_strobe_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !$stable(byte_o) |=> (strobe_o != $past(strobe_o)))
      else $error("byte change not followed by strobe");

   assert_stable_at_strobe_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (strobe_o != $past(strobe_o)) |-> $stable(byte_o))
      else $error("byte changed at strobe edge");

   // R9: pulses only when enabled
   assert_irq_gated_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(irq_pull_o) |-> $past(irq_en_i))
      else $error("interrupt pulse while disabled");

   // R8: pulse and strobe edge coincide
   assert_irq_with_strobe_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(irq_pull_o) |-> (strobe_o != $past(strobe_o)))
      else $error("interrupt pulse without strobe");

endmodule

// File: tb/sim_rbyte_harvester.sv
module sim_rbyte_harvester;

   localparam int DIV   = 3;
   localparam int LOWC  = 30;
   localparam int LIMIT = 150_000;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       noise = 1'b0;
   logic       pend = 1'b0;
   logic       en = 1'b0;
   logic [7:0] byte_o;
   logic       strobe;
   logic       irq;

   always #5 clk = ~clk;

   rbyte_harvester #(
      .BYTE_W(8), .SAMPLE_DIV(DIV), .SYNC_STAGES(2),
      .IRQ_LOW_CYCLES(LOWC), .CLK_PERIOD_PS(10_000), .LSB_FIRST(1'b1)
   ) u0 (
      .clk_i(clk), .rst_ni(rst_n), .noise_i(noise), .pending_i(pend),
      .irq_en_i(en), .byte_o(byte_o), .strobe_o(strobe), .irq_pull_o(irq)
   );

   int tests = 0, fails = 0, total = 0;
   int n = 0, mcnt = 0, bytes = 0, irq_w = 0, first_n = 0;
   logic [7:0] macc = '0, prev_byte = '0;
   logic prev_strobe = 1'b0, prev_irq = 1'b0, pend_p1 = 1'b0, pend_p2 = 1'b0, en_edge = 1'b0;
   string byte_req = "R2";

   // Noise bit for sample index j: byte k of the stream is (k*7+3) mod 256.
   function automatic logic patbit(input int j);
      logic [7:0] v;
      v = 8'((j / 8) * 7 + 3);
      return v[j % 8];
   endfunction

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   endtask

   task automatic cyc();
      pend_p2 = pend_p1;
      pend_p1 = pend;
      en_edge = en;
      @(posedge clk);
      #2;
      n++;
      total++;
      if (total > LIMIT) begin
         fails++;
         $display("FAIL watchdog actual=%0d expected=%0d", total, LIMIT);
         finish_run();
      end
      if (strobe !== prev_strobe) begin
         chk(mcnt == 8, "R7", mcnt, 8);
         chk(byte_o == macc, byte_req, byte_o, macc);
         chk(prev_byte == byte_o, "R6", prev_byte, byte_o);
         chk(!pend_p2, "R4", pend_p2, 0);
         chk(irq == en_edge, en_edge ? "R8" : "R9", irq, en_edge);
         chk(!prev_irq, "R10", prev_irq, 0);
         if (bytes == 0) first_n = n;
         mcnt = 0;
         bytes++;
         byte_req = "R2";
      end else if (irq && !prev_irq) begin
         chk(1'b0, "R9", irq, 0);
      end
      if (irq) irq_w++;
      else begin
         if (prev_irq) chk(irq_w == LOWC, "R8", irq_w, LOWC);
         irq_w = 0;
      end
      if (n % DIV == 0 && mcnt < 8) begin
         macc = {patbit(n / DIV - 1), macc[7:1]};
         mcnt++;
      end
      noise = patbit(n / DIV);
      prev_strobe = strobe;
      prev_irq = irq;
      prev_byte = byte_o;
   endtask

   task automatic run_bytes(input int cnt);
      int target;
      int guard;
      target = bytes + cnt;
      guard = 0;
      while (bytes < target && guard < 20_000) begin
         cyc();
         guard++;
      end
      chk(bytes >= target, "R7", bytes, target);
   endtask

   task automatic model_reset();
      n = 0; mcnt = 0; macc = '0; irq_w = 0; bytes = 0;
      prev_strobe = 1'b0; prev_irq = 1'b0; prev_byte = '0;
      pend_p1 = pend; pend_p2 = pend;
      noise = patbit(0);
   endtask

   initial begin
      logic [7:0] saved_b;
      logic saved_s;
      int toggles;

      // R11: reset state
      noise = patbit(0);
      repeat (3) @(posedge clk);
      #2;
      chk(byte_o == 8'h00, "R11", byte_o, 0);
      chk(strobe == 1'b0, "R11", strobe, 0);
      chk(irq == 1'b0, "R11", irq, 0);
      model_reset();
      rst_n = 1'b1;

      // R1: first byte timing, interrupts disabled
      run_bytes(1);
      chk(first_n == 8 * DIV + 2, "R1", first_n, 8 * DIV + 2);
      // R2: sweep over all byte values, R9 line stays released
      run_bytes(299);

      // R8 / R10: interrupts on, pulse longer than one byte period
      en = 1'b1;
      run_bytes(40);

      // R5 / R3: host stalls over several byte periods
      pend = 1'b1;
      cyc(); cyc(); cyc();
      saved_b = byte_o;
      saved_s = strobe;
      toggles = bytes;
      repeat (200) cyc();
      chk(strobe == saved_s, "R5", strobe, saved_s);
      chk(byte_o == saved_b, "R5", byte_o, saved_b);
      chk(bytes == toggles, "R5", bytes, toggles);
      byte_req = "R3";
      pend = 1'b0;
      run_bytes(2);

      // Mixed host timing and enable changes
      for (int i = 0; i < 3000; i++) begin
         if (i % 13 == 0) pend = ~pend;
         if (i % 97 == 0) en = ~en;
         cyc();
      end
      pend = 1'b0;
      en = 1'b1;
      run_bytes(3);

      // R11: reset in the middle of a pulse
      begin
         int guard;
         guard = 0;
         while (!irq && guard < 5000) begin cyc(); guard++; end
      end
      chk(irq == 1'b1, "R8", irq, 1);
      repeat (5) cyc();
      rst_n = 1'b0;
      #1;
      chk(irq == 1'b0, "R11", irq, 0);
      chk(strobe == 1'b0, "R11", strobe, 0);
      chk(byte_o == 8'h00, "R11", byte_o, 0);
      repeat (2) @(posedge clk);
      #2;
      model_reset();
      rst_n = 1'b1;
      run_bytes(1);
      chk(first_n == 8 * DIV + 2, "R11", first_n, 8 * DIV + 2);
      run_bytes(2);

      finish_run();
   end

endmodule